// File: doc/BRIEF.md
# SDR SDRAM Burst Data Path

This block sits beside the command scheduler of a single-data-rate SDRAM controller. It owns the 32-bit data bus and its four byte-mask lines. The scheduler registers its commands onto the memory pins at the same clock edge that this block samples `cmd_rd`, `cmd_wr` or `cmd_stop`. The cycle after that sample is called the command slot. Every later burst beat takes one more slot.

For writes, the block drives the host word and its byte mask onto the pins in each beat slot. It enables the bus driver only while those beats last. For reads, it places the host's per-beat byte masks on the mask lines early enough to meet the two-clock read-mask latency. It also follows each beat through a CAS-latency pipeline, captures the returned word, and tags it with its column address and its byte enables.

A beat counter handles fixed bursts of 1, 2, 4 or 8 beats and open-ended page bursts. It produces the column order of each beat, sequential or interleaved. A new read or write restarts the counter, and a stop command cuts the burst short.

Top module: `sdr_burst_dp`

## Requirements
- R1: While `rst` is high, and in the cycle after it, every output is zero: `dq_oe`, `dq_out`, `dqm_out`, `rd_valid`, `rd_be`, `rd_data` and `rd_col`.
- R2: When `cmd_wr` is sampled, `host_wdata` appears on `dq_out` in the next cycle with `dq_oe` high. Each later beat takes the word sampled one clock earlier. `dq_oe` is high exactly in write beat slots and drops in the slot after the last beat.
- R3: In a write beat slot, `dqm_out` carries the `host_mask` sampled with that beat's data. Write mask latency is zero.
- R4: `cfg_cl` selects the CAS latency: 0 means 2 and 1 means 3. The word on `dq_in` in read beat slot k plus CL is captured, and it shows on `rd_data` with `rd_valid` high one cycle later.
- R5: For a read beat, the `host_mask` sampled with that beat appears on `dqm_out` two slots before its data: in the beat slot when CL=2, and one slot later when CL=3. With the word, `rd_be` is the bitwise inverse of that mask. A mask bit of 1 disables its byte, and bit i covers `dq` bits 8i+7..8i.
- R6: `cfg_bl` sets the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives a page burst. Other codes act as 1. A fixed burst stops by itself after that many beats.
- R7: With `cfg_ilv`=0, beat k of a fixed burst of length L reads the column whose bits above log2(L) equal the start column's, and whose low bits are (start + k) mod L.
- R8: With `cfg_ilv`=1, the low log2(L) bits of beat k's column are the start column's low bits XOR k.
- R9: A page burst steps its column by one each beat, modulo 256, and ignores `cfg_ilv`. It runs until a stop or a new read or write.
- R10: `cmd_stop` ends the current burst, and its own slot carries no beat. After a read stop, exactly CL more words return. A stop with no burst running has no effect.
- R11: A read or write sampled during a running burst restarts the beat count at the new column in the next slot. When it is sampled together with `cmd_stop`, the new command wins.
- R12: `dq_oe` is never high in a read beat slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cl | input | 1 | CAS latency select, 0 means 2, 1 means 3 |
| cfg_bl | input | 3 | Burst length code |
| cfg_ilv | input | 1 | 1 selects interleaved beat order |
| cmd_rd | input | 1 | Read command sampled this edge |
| cmd_wr | input | 1 | Write command sampled this edge |
| cmd_stop | input | 1 | Burst stop sampled this edge |
| cmd_col | input | 8 | Start column of the command |
| host_wdata | input | 32 | Write word for the beat being issued |
| host_mask | input | 4 | Byte mask for the beat being issued |
| dq_in | input | 32 | Data bus as seen from the pads |
| dq_out | output | 32 | Data bus drive value |
| dq_oe | output | 1 | Data bus drive enable |
| dqm_out | output | 4 | Byte mask lines |
| rd_valid | output | 1 | A read word is present |
| rd_data | output | 32 | Captured read word |
| rd_be | output | 4 | Byte enables of the captured word |
| rd_col | output | 8 | Column address of the captured word |

## Verification
The assertions assume the following about the inputs. At most one of `cmd_rd` and `cmd_wr` is high in any cycle. The configuration inputs stay fixed while a burst or its read return is in flight. No write is issued while read words are still returning, because bus turnaround belongs to the scheduler. The stimulus meets these rules by changing the configuration only after long idle gaps, by never raising two commands other than a read together with a stop, and by leaving at least CL+3 idle cycles between the end of a read and the next write.

// File: rtl/sdr_dp_pkg.sv
package sdr_dp_pkg;

  typedef enum logic [2:0] {
    BL_ONE   = 3'd0,
    BL_TWO   = 3'd1,
    BL_FOUR  = 3'd2,
    BL_EIGHT = 3'd3,
    BL_PAGE  = 3'd7
  } burst_code_e;

  localparam int CL_MIN = 2;
  localparam int CL_MAX = 3;

  // Highest beat index of a fixed burst; a page burst spans the whole column space.
  function automatic int unsigned burst_span(input logic [2:0] code, input int unsigned col_w);
    case (code)
      BL_TWO:   return 1;
      BL_FOUR:  return 3;
      BL_EIGHT: return 7;
      BL_PAGE:  return (32'd1 << col_w) - 1;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/sdr_dp_burst_seq.sv
module sdr_dp_burst_seq
  import sdr_dp_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_stop,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [2:0]       cfg_bl,
  input  logic             cfg_ilv,
  output logic             issue_rd,
  output logic             issue_wr,
  output logic             beat_rd,
  output logic [COL_W-1:0] beat_col
);

  logic             act, wr;
  logic [COL_W-1:0] idx, base, span, nidx, nbase, offs, issue_col;
  logic             full, last, fresh, go, nwr;

  always_comb begin
    span      = COL_W'(burst_span(cfg_bl, COL_W));
    full      = (cfg_bl == BL_PAGE);
    last      = act && !full && (idx == span);
    fresh     = cmd_rd | cmd_wr;
    go        = fresh | (act & ~cmd_stop & ~last);
    nidx      = fresh ? '0 : idx + 1'b1;
    nbase     = fresh ? cmd_col : base;
    nwr       = fresh ? cmd_wr : wr;
    offs      = (cfg_ilv && !full) ? (nbase ^ nidx) : (nbase + nidx);
    issue_col = (nbase & ~span) | (offs & span);
    issue_rd  = go & ~nwr;
    issue_wr  = go & nwr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act      <= 1'b0;
      wr       <= 1'b0;
      idx      <= '0;
      base     <= '0;
      beat_rd  <= 1'b0;
      beat_col <= '0;
    end else begin
      act      <= go;
      wr       <= nwr;
      idx      <= nidx;
      base     <= nbase;
      beat_rd  <= issue_rd;
      beat_col <= issue_col;
    end
  end

endmodule

// File: rtl/sdr_dp_rd_pipe.sv
module sdr_dp_rd_pipe
  import sdr_dp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MASK_W = DATA_W / 8,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cl_long,
  input  logic              beat_rd,
  input  logic [COL_W-1:0]  beat_col,
  input  logic [MASK_W-1:0] host_mask,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [MASK_W-1:0] rd_be,
  output logic [COL_W-1:0]  rd_col
);

  localparam int DEPTH     = CL_MAX;
  localparam int SHORT_TAP = CL_MIN - 1;
  localparam int LONG_TAP  = CL_MAX - 1;

  logic [MASK_W-1:0] mask0;
  logic              st_v [DEPTH];
  logic [COL_W-1:0]  st_c [DEPTH];
  logic [MASK_W-1:0] st_m [DEPTH];
  logic              tap_v;
  logic [COL_W-1:0]  tap_c;
  logic [MASK_W-1:0] tap_m;

  // Beat tracking stages; stage j holds a beat j+1 slots after it was issued.
  always_ff @(posedge clk) begin
    if (rst) begin
      mask0 <= '0;
      for (int j = 0; j < DEPTH; j++) begin
        st_v[j] <= 1'b0;
        st_c[j] <= '0;
        st_m[j] <= '0;
      end
    end else begin
      mask0   <= host_mask;
      st_v[0] <= beat_rd;
      st_c[0] <= beat_col;
      st_m[0] <= mask0;
      for (int j = 1; j < DEPTH; j++) begin
        st_v[j] <= st_v[j-1];
        st_c[j] <= st_c[j-1];
        st_m[j] <= st_m[j-1];
      end
    end
  end

  always_comb begin
    tap_v = cl_long ? st_v[LONG_TAP] : st_v[SHORT_TAP];
    tap_c = cl_long ? st_c[LONG_TAP] : st_c[SHORT_TAP];
    tap_m = cl_long ? st_m[LONG_TAP] : st_m[SHORT_TAP];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_be    <= '0;
      rd_col   <= '0;
    end else begin
      rd_valid <= tap_v;
      rd_be    <= tap_v ? ~tap_m : '0;
      if (tap_v) begin
        rd_data <= dq_in;
        rd_col  <= tap_c;
      end
    end
  end

endmodule

// File: rtl/sdr_dp_pin_drive.sv
module sdr_dp_pin_drive #(
  parameter int DATA_W = 32,
  parameter int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cl_long,
  input  logic              issue_wr,
  input  logic              issue_rd,
  input  logic              beat_rd,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [MASK_W-1:0] host_mask,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [MASK_W-1:0] dqm_out
);

  logic [MASK_W-1:0] rd_mask_q, dqm_nxt;

  // Write masks go out with their data; read masks must lead the data by two slots.
  always_comb begin
    if (issue_wr)     dqm_nxt = host_mask;
    else if (cl_long) dqm_nxt = beat_rd ? rd_mask_q : '0;
    else              dqm_nxt = issue_rd ? host_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_mask_q <= '0;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      dqm_out   <= '0;
    end else begin
      rd_mask_q <= host_mask;
      dq_out    <= issue_wr ? host_wdata : '0;
      dq_oe     <= issue_wr;
      dqm_out   <= dqm_nxt;
    end
  end

endmodule

// File: rtl/sdr_burst_dp.sv
module sdr_burst_dp #(
  parameter int DATA_W = 32,
  parameter int MASK_W = DATA_W / 8,
  parameter int COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cl,
  input  logic [2:0]        cfg_bl,
  input  logic              cfg_ilv,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic              cmd_stop,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [MASK_W-1:0] host_mask,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [MASK_W-1:0] dqm_out,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [MASK_W-1:0] rd_be,
  output logic [COL_W-1:0]  rd_col
);

  logic             issue_rd, issue_wr, beat_rd;
  logic [COL_W-1:0] beat_col;

  sdr_dp_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cmd_rd   (cmd_rd),
    .cmd_wr   (cmd_wr),
    .cmd_stop (cmd_stop),
    .cmd_col  (cmd_col),
    .cfg_bl   (cfg_bl),
    .cfg_ilv  (cfg_ilv),
    .issue_rd (issue_rd),
    .issue_wr (issue_wr),
    .beat_rd  (beat_rd),
    .beat_col (beat_col)
  );

  sdr_dp_pin_drive #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_drive (
    .clk        (clk),
    .rst        (rst),
    .cl_long    (cfg_cl),
    .issue_wr   (issue_wr),
    .issue_rd   (issue_rd),
    .beat_rd    (beat_rd),
    .host_wdata (host_wdata),
    .host_mask  (host_mask),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe),
    .dqm_out    (dqm_out)
  );

  sdr_dp_rd_pipe #(.DATA_W(DATA_W), .MASK_W(MASK_W), .COL_W(COL_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .cl_long   (cfg_cl),
    .beat_rd   (beat_rd),
    .beat_col  (beat_col),
    .host_mask (host_mask),
    .dq_in     (dq_in),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_be     (rd_be),
    .rd_col    (rd_col)
  );

endmodule

// File: rtl/sdr_burst_dp_chk.sv
module sdr_burst_dp_chk #(
  parameter int DATA_W = 32,
  parameter int MASK_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_cl,
  input logic              cmd_rd,
  input logic              cmd_wr,
  input logic              cmd_stop,
  input logic [DATA_W-1:0] host_wdata,
  input logic [MASK_W-1:0] host_mask,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic [MASK_W-1:0] dqm_out,
  input logic              rd_valid,
  input logic [MASK_W-1:0] rd_be,
  input logic              beat_rd
);

  p_wr_launch_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> dq_oe && (dq_out == $past(host_wdata)));

  p_wr_mask_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_wr |=> dqm_out == $past(host_mask));

  p_rd_lat3_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && cfg_cl) |-> $past(beat_rd, 4));

  p_rd_lat2_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !cfg_cl) |-> $past(beat_rd, 3));

  p_rd_mask_lead_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_be == ~$past(dqm_out, 3));

  p_stop_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_stop && !cmd_rd && !cmd_wr) |=> !dq_oe && !beat_rd);

  p_restart_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_rd |=> beat_rd && !dq_oe);

  p_no_drive_on_read_r12: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !beat_rd);

endmodule

bind sdr_burst_dp sdr_burst_dp_chk #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_cl     (cfg_cl),
  .cmd_rd     (cmd_rd),
  .cmd_wr     (cmd_wr),
  .cmd_stop   (cmd_stop),
  .host_wdata (host_wdata),
  .host_mask  (host_mask),
  .dq_out     (dq_out),
  .dq_oe      (dq_oe),
  .dqm_out    (dqm_out),
  .rd_valid   (rd_valid),
  .rd_be      (rd_be),
  .beat_rd    (beat_rd)
);

// File: tb/sdr_burst_dp_test.sv
`timescale 1ns/1ps
module sdr_burst_dp_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_cl, cfg_ilv;
  logic [2:0]  cfg_bl;
  logic        cmd_rd, cmd_wr, cmd_stop;
  logic [7:0]  cmd_col;
  logic [31:0] host_wdata, dq_in, dq_out, rd_data;
  logic [3:0]  host_mask, dqm_out, rd_be;
  logic        dq_oe, rd_valid;
  logic [7:0]  rd_col;

  always #2 clk = ~clk;

  sdr_burst_dp uut (
    .clk(clk), .rst(rst), .cfg_cl(cfg_cl), .cfg_bl(cfg_bl), .cfg_ilv(cfg_ilv),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_stop(cmd_stop), .cmd_col(cmd_col),
    .host_wdata(host_wdata), .host_mask(host_mask), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .dqm_out(dqm_out), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_be(rd_be), .rd_col(rd_col)
  );

  // Free-running stimulus patterns, changed away from the active edge.
  logic [15:0] pat = 16'd0;
  always @(negedge clk) pat <= pat + 16'd1;
  assign host_wdata = {pat, pat ^ 16'h5A3C};
  assign host_mask  = pat[3:0] ^ pat[6:3];
  assign dq_in      = {pat + 16'h1234, ~pat};

  int    checks = 0, errors = 0, vcount = 0, v0 = 0;
  bit    done = 1'b0;
  string scen = "R1 reset";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s during %s: act %h exp %h", tag, scen, act, exp);
    end
  endtask

  // Behavioural reference model
  typedef struct {int due; int col; logic [3:0] mask;} pend_t;
  pend_t       pq[$];
  pend_t       pe;
  int          m_act, m_wr, m_idx, m_base, m_len, ecnt, cl, col, blk, off;
  bit          prev_rd;
  logic [3:0]  prev_mask;
  logic        e_oe, e_valid;
  logic [31:0] e_dq, e_data;
  logic [3:0]  e_dqm, e_be;
  logic [7:0]  e_col;

  function automatic int blen(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 0;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; m_wr = 0; m_idx = 0; m_base = 0; ecnt = 0;
      prev_rd = 1'b0; prev_mask = '0;
      e_oe = 1'b0; e_valid = 1'b0; e_dq = '0; e_data = '0;
      e_dqm = '0; e_be = '0; e_col = '0;
      pq.delete();
    end else begin
      m_len = blen(cfg_bl);
      cl    = cfg_cl ? 3 : 2;
      e_valid = 1'b0;
      e_be    = '0;
      if (pq.size() > 0 && pq[0].due == ecnt) begin
        e_valid = 1'b1;
        e_data  = dq_in;
        e_be    = ~pq[0].mask;
        e_col   = pq[0].col[7:0];
        void'(pq.pop_front());
      end
      if (cmd_rd || cmd_wr) begin
        m_act = 1; m_wr = cmd_wr ? 1 : 0; m_idx = 0; m_base = cmd_col;
      end else if (m_act == 1 && !cmd_stop && (m_len == 0 || m_idx + 1 < m_len)) begin
        m_idx = m_idx + 1;
      end else begin
        m_act = 0;
      end
      if (m_len == 0) col = (m_base + m_idx) % 256;
      else begin
        blk = m_base - (m_base % m_len);
        off = cfg_ilv ? ((m_base % m_len) ^ m_idx) : (((m_base % m_len) + m_idx) % m_len);
        col = blk + off;
      end
      e_oe = (m_act == 1 && m_wr == 1);
      e_dq = e_oe ? host_wdata : '0;
      if (e_oe) e_dqm = host_mask;
      else if (cfg_cl) e_dqm = prev_rd ? prev_mask : '0;
      else e_dqm = (m_act == 1) ? host_mask : '0;
      prev_rd   = (m_act == 1 && m_wr == 0);
      prev_mask = host_mask;
      if (m_act == 1 && m_wr == 0) begin
        pe.due = ecnt + cl + 1; pe.col = col; pe.mask = host_mask;
        pq.push_back(pe);
      end
      ecnt++;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) vcount++;
      chk(dq_oe === e_oe, "R2/R12 dq_oe", 32'(dq_oe), 32'(e_oe));
      chk(dq_out === e_dq, "R2 dq_out", dq_out, e_dq);
      chk(dqm_out === e_dqm, "R3/R5 dqm_out", 32'(dqm_out), 32'(e_dqm));
      chk(rd_valid === e_valid, "R4 rd_valid", 32'(rd_valid), 32'(e_valid));
      chk(rd_be === e_be, "R5 rd_be", 32'(rd_be), 32'(e_be));
      if (e_valid) begin
        chk(rd_data === e_data, "R4 rd_data", rd_data, e_data);
        chk(rd_col === e_col, "R7/R8/R9 rd_col", 32'(rd_col), 32'(e_col));
      end
    end
  end

  task automatic set_cfg(input logic cl_i, input logic [2:0] bl_i, input logic ilv_i);
    cfg_cl = cl_i; cfg_bl = bl_i; cfg_ilv = ilv_i;
    @(negedge clk);
  endtask

  task automatic send(input logic r, input logic w, input logic s, input logic [7:0] c);
    cmd_rd = r; cmd_wr = w; cmd_stop = s; cmd_col = c;
    @(negedge clk);
    cmd_rd = 1'b0; cmd_wr = 1'b0; cmd_stop = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; cfg_cl = 1'b0; cfg_bl = 3'd2; cfg_ilv = 1'b0;
    cmd_rd = 1'b0; cmd_wr = 1'b0; cmd_stop = 1'b0; cmd_col = '0;
    repeat (3) @(negedge clk);
    chk(dq_oe === 1'b0, "R1 dq_oe", 32'(dq_oe), 0);
    chk(dq_out === '0, "R1 dq_out", dq_out, 0);
    chk(dqm_out === '0, "R1 dqm_out", 32'(dqm_out), 0);
    chk(rd_valid === 1'b0, "R1 rd_valid", 32'(rd_valid), 0);
    chk(rd_be === '0, "R1 rd_be", 32'(rd_be), 0);
    chk(rd_data === '0, "R1 rd_data", rd_data, 0);
    rst = 1'b0;
    idle(2);

    scen = "R6/R7 BL4 sequential CL2";
    set_cfg(1'b0, 3'd2, 1'b0);
    send(0, 1, 0, 8'h13); idle(6);
    send(1, 0, 0, 8'h13); idle(8);

    scen = "R8 BL8 interleave CL3";
    set_cfg(1'b1, 3'd3, 1'b1);
    send(1, 0, 0, 8'h2D); idle(12);
    send(0, 1, 0, 8'h2D); idle(10);

    scen = "R6 BL1 and BL2";
    set_cfg(1'b1, 3'd0, 1'b0);
    send(1, 0, 0, 8'h05); idle(8);
    set_cfg(1'b0, 3'd1, 1'b1);
    send(1, 0, 0, 8'h07); idle(8);

    scen = "R11 back-to-back reads";
    set_cfg(1'b1, 3'd2, 1'b0);
    send(1, 0, 0, 8'h10);
    send(1, 0, 0, 8'h21); idle(10);
    v0 = vcount;
    send(1, 0, 1, 8'h32); idle(10);
    chk(vcount - v0 == 4, "R11 read with stop", 32'(vcount - v0), 4);

    scen = "R10 read stop CL3";
    set_cfg(1'b1, 3'd3, 1'b0);
    v0 = vcount;
    send(1, 0, 0, 8'h40); idle(2);
    send(0, 0, 1, 8'h00); idle(10);
    chk(vcount - v0 == 3, "R10 words CL3", 32'(vcount - v0), 3);

    scen = "R10 read stop CL2";
    set_cfg(1'b0, 3'd3, 1'b0);
    v0 = vcount;
    send(1, 0, 0, 8'h48); idle(1);
    send(0, 0, 1, 8'h00); idle(10);
    chk(vcount - v0 == 2, "R10 words CL2", 32'(vcount - v0), 2);

    scen = "R10 stop while idle";
    send(0, 0, 1, 8'h00); idle(4);

    scen = "R9/R10 page write stop";
    set_cfg(1'b0, 3'd7, 1'b0);
    send(0, 1, 0, 8'hFC); idle(5);
    send(0, 0, 1, 8'h00); idle(6);

    scen = "R9 page read wrap";
    set_cfg(1'b1, 3'd7, 1'b1);
    v0 = vcount;
    send(1, 0, 0, 8'hFD); idle(6);
    send(0, 0, 1, 8'h00); idle(10);
    chk(vcount - v0 == 7, "R9 page words", 32'(vcount - v0), 7);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog during %s: act 0 exp 1", scen);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule